// File: doc/BRIEF.md
# Configurable Ready/Valid Channel Queue

This block buffers a single valid/ready channel between a producer and a consumer. A copy is placed on each channel of a multi-channel bus to separate the timing of the requester from that of the responder. Words leave in the order they arrived. No word is lost and no word is repeated, whatever pattern the two handshakes follow.

Three parameters shape the queue. `DEPTH` sets the number of storage slots. When `DEPTH` is zero, the block is a plain combinational connection. `BYPASS_EMPTY` lets a word cross an empty queue in the same cycle it arrives. `ACCEPT_ON_DRAIN` lets a full queue accept a word in the cycle its head is taken, so a one-slot queue can move one word every cycle. The defaults are two slots with both options off. If only a depth is chosen, both options stay off.

Top module: `rv_chan_queue`

## Requirements
- R1: With every parameter at its default, the queue holds two words, does not bypass, and does not accept while full.
- R2: While `rst` is high and after it falls, a queue with storage is empty: `deq_valid` is low while `enq_valid` is low, and `enq_ready` is high.
- R3: Words leave in the order they were accepted, each exactly once, under any valid/ready pattern.
- R4: Without accept-on-drain, a queue holding `DEPTH` words drives `enq_ready` low.
- R5: Without bypass, a word accepted into an empty queue first appears on `deq_valid`/`deq_data` in the cycle after its acceptance.
- R6: With bypass, `enq_valid` into an empty queue raises `deq_valid` in the same cycle, with `deq_data` equal to `enq_data`. If the consumer takes the word in that cycle, nothing is stored.
- R7: With accept-on-drain, a full queue drives `enq_ready` high whenever `deq_ready` is high, so a one-slot queue moves one word per cycle. While `deq_ready` is low, it drives `enq_ready` low.
- R8: With `DEPTH` = 0, `deq_valid` = `enq_valid`, `deq_data` = `enq_data` and `enq_ready` = `deq_ready`, all combinationally.
- R9: `enq_ready` never depends on `enq_valid` in the same cycle.
- R10: While a stored word is offered and not taken, `deq_valid` stays high and `deq_data` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | Producer offers a word |
| enq_ready | output | 1 | Queue can take a word this cycle |
| enq_data | input | WIDTH | Word from the producer |
| deq_valid | output | 1 | Queue offers a word |
| deq_ready | input | 1 | Consumer takes the offered word |
| deq_data | output | WIDTH | Word to the consumer |

## Verification
The embedded properties check four things on every cycle:
- the occupancy stays within bounds;
- a stalled head word stays valid and unchanged;
- a refused producer implies the queue has a word to offer;
- without bypass, output valid only rises after an accepted input.

Other behaviours need the bench's directed scenarios, which drive four configurations side by side. These are the first-in first-out order, the same-cycle bypass, the full-rate throughput of the one-slot accept-on-drain queue, and the independence of `enq_ready` from `enq_valid`.

// File: rtl/rv_chan_queue.sv
module rv_chan_queue #(
  parameter int WIDTH           = 8,
  parameter int DEPTH           = 2,
  parameter bit BYPASS_EMPTY    = 1'b0,
  parameter bit ACCEPT_ON_DRAIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [WIDTH-1:0] enq_data,
  output logic             deq_valid,
  input  logic             deq_ready,
  output logic [WIDTH-1:0] deq_data
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign deq_valid = enq_valid;
      assign deq_data  = enq_data;
      assign enq_ready = deq_ready;
    end else begin : g_store
      localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
      localparam int CW = $clog2(DEPTH + 1);
      localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
      localparam logic [CW-1:0] FULLC = CW'(DEPTH);

      logic [WIDTH-1:0] slots [DEPTH];
      logic [PW-1:0]    wr_ptr, rd_ptr;
      logic [CW-1:0]    count;
      logic             empty, full, enq_fire, deq_fire, bypass, do_wr, do_rd;

      assign empty = (count == '0);
      assign full  = (count == FULLC);

      assign enq_ready = !full || (ACCEPT_ON_DRAIN && deq_ready);
      assign deq_valid = !empty || (BYPASS_EMPTY && enq_valid);
      assign deq_data  = (BYPASS_EMPTY && empty) ? enq_data : slots[rd_ptr];

      assign enq_fire = enq_valid && enq_ready;
      assign deq_fire = deq_valid && deq_ready;
      assign bypass   = BYPASS_EMPTY && empty;
      assign do_wr    = enq_fire && !(bypass && deq_fire);
      assign do_rd    = deq_fire && !bypass;

      always_ff @(posedge clk) begin
        if (do_wr) slots[wr_ptr] <= enq_data;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          wr_ptr <= '0;
          rd_ptr <= '0;
          count  <= '0;
        end else begin
          if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
          if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
          if (do_wr && !do_rd)      count <= count + 1'b1;
          else if (do_rd && !do_wr) count <= count - 1'b1;
        end
      end

      // R4
      no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= FULLC);

      // R10
      head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (deq_valid && !deq_ready && !empty) |=> (deq_valid && deq_data == $past(deq_data)));

      // R7
      refuse_has_word_chk: assert property (@(posedge clk) disable iff (rst)
        !enq_ready |-> deq_valid);

      if (!BYPASS_EMPTY) begin : g_nobyp
        // R5
        valid_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
          $rose(deq_valid) |-> $past(enq_valid && enq_ready));
      end
    end
  endgenerate

endmodule

// File: tb/test_rv_chan_queue.sv
module test_rv_chan_queue;
  localparam int W = 8;
  localparam int N = 4;
  localparam int DEP [N] = '{2, 1, 1, 0};
  localparam bit BYP [N] = '{1'b0, 1'b1, 1'b0, 1'b0};
  localparam bit ACD [N] = '{1'b0, 1'b0, 1'b1, 1'b0};
  localparam int NV = 20;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1,1'b0,8'h01}, {1'b1,1'b0,8'h02}, {1'b1,1'b1,8'h03}, {1'b0,1'b1,8'h04},
    {1'b1,1'b1,8'h05}, {1'b1,1'b1,8'h06}, {1'b0,1'b0,8'h07}, {1'b1,1'b0,8'h08},
    {1'b1,1'b0,8'h09}, {1'b0,1'b1,8'h0a}, {1'b1,1'b1,8'h0b}, {1'b1,1'b0,8'h0c},
    {1'b0,1'b1,8'h0d}, {1'b0,1'b1,8'h0e}, {1'b1,1'b1,8'h0f}, {1'b1,1'b1,8'h10},
    {1'b1,1'b0,8'h11}, {1'b0,1'b0,8'h12}, {1'b1,1'b1,8'h13}, {1'b0,1'b1,8'h14}};

  logic clk = 1'b0, rst = 1'b1;
  logic iv = 1'b0, ordy = 1'b0;
  logic [W-1:0] id = '0;
  logic [N-1:0] irdy, ov;
  logic [W-1:0] od [N];
  logic [W-1:0] sb [N][$];
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  for (genvar k = 0; k < N; k++) begin : g_dut
    if (k == 0) begin : g_def
      rv_chan_queue i_rv_chan_queue (
        .clk(clk), .rst(rst), .enq_valid(iv), .enq_ready(irdy[k]), .enq_data(id),
        .deq_valid(ov[k]), .deq_ready(ordy), .deq_data(od[k]));
    end else begin : g_var
      rv_chan_queue #(.WIDTH(W), .DEPTH(DEP[k]), .BYPASS_EMPTY(BYP[k]),
                      .ACCEPT_ON_DRAIN(ACD[k])) i_rv_chan_queue (
        .clk(clk), .rst(rst), .enq_valid(iv), .enq_ready(irdy[k]), .enq_data(id),
        .deq_valid(ov[k]), .deq_ready(ordy), .deq_data(od[k]));
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R3 scoreboard per instance
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int k = 0; k < N; k++) begin
        if (iv && irdy[k]) sb[k].push_back(id);
        if (ov[k] && ordy) begin
          if (sb[k].size() == 0) chk(1'b0, "R3 extra word", od[k], 0);
          else begin
            logic [W-1:0] e;
            e = sb[k].pop_front();
            chk(od[k] == e, "R3 order", od[k], e);
          end
        end
      end
    end
  end

  task automatic drive(input logic v, input logic r, input logic [W-1:0] d);
    @(posedge clk); #1;
    iv = v; ordy = r; id = d;
  endtask

  task automatic drain();
    for (int j = 0; j < 6; j++) drive(1'b0, 1'b1, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(ov[k] == 1'b0, "R2 valid in reset", ov[k], 0);
      chk(irdy[k] == 1'b1, "R2 ready in reset", irdy[k], 1);
    end
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(ov[0] == 1'b0 && irdy[0] == 1'b1, "R2 after reset", {ov[0], irdy[0]}, 2'b01);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9], VEC[i][8], VEC[i][7:0]);
      @(negedge clk);
      chk(ov[3] == VEC[i][9] && od[3] == VEC[i][7:0] && irdy[3] == VEC[i][8],
          "R8 passthrough", {ov[3], irdy[3], od[3]}, {VEC[i][9], VEC[i][8], VEC[i][7:0]});
    end
    drain();

    drive(1'b1, 1'b0, 8'h11);
    @(negedge clk); chk(irdy[0] == 1'b1, "R4 empty ready", irdy[0], 1);
    drive(1'b1, 1'b0, 8'h12);
    @(negedge clk); chk(irdy[0] == 1'b1, "R1 one of two", irdy[0], 1);
    drive(1'b1, 1'b0, 8'h13);
    @(negedge clk);
    chk(irdy[0] == 1'b0, "R1 R4 full at two", irdy[0], 0);
    chk(irdy[2] == 1'b0, "R7 full no drain", irdy[2], 0);
    chk(irdy[1] == 1'b0, "R4 flow full", irdy[1], 0);
    chk(ov[0] && od[0] == 8'h11, "R10 head offered", od[0], 8'h11);
    @(posedge clk); #1 iv = 1'b0;
    #1 chk(irdy[0] == 1'b0, "R9 ready without valid", irdy[0], 0);
    iv = 1'b1;
    @(negedge clk); chk(irdy[0] == 1'b0, "R9 ready with valid", irdy[0], 0);
    drive(1'b0, 1'b0, 8'h00);
    @(negedge clk);
    chk(ov[0] && od[0] == 8'h11, "R10 head held", od[0], 8'h11);
    drain();

    drive(1'b1, 1'b0, 8'ha5);
    @(negedge clk);
    chk(ov[0] == 1'b0, "R5 no same-cycle valid", ov[0], 0);
    chk(ov[2] == 1'b0, "R5 pipe no bypass", ov[2], 0);
    chk(ov[1] && od[1] == 8'ha5, "R6 bypass data", od[1], 8'ha5);
    chk(ov[3] == 1'b1, "R8 zero depth valid", ov[3], 1);
    drive(1'b0, 1'b0, 8'h00);
    @(negedge clk);
    chk(ov[0] && od[0] == 8'ha5, "R5 next-cycle valid", od[0], 8'ha5);

    drive(1'b1, 1'b1, 8'h3c);
    @(negedge clk); chk(irdy[2] == 1'b1, "R7 full accepts on drain", irdy[2], 1);
    for (int j = 0; j < 6; j++) begin
      drive(1'b1, 1'b1, 8'(8'h40 + j));
      @(negedge clk);
      chk(irdy[2] && ov[2], "R7 full rate", {irdy[2], ov[2]}, 2'b11);
    end
    drain();

    drive(1'b1, 1'b1, 8'h77);
    @(negedge clk); chk(ov[1] && od[1] == 8'h77, "R6 bypass taken", od[1], 8'h77);
    drive(1'b0, 1'b1, 8'h00);
    @(negedge clk); chk(ov[1] == 1'b0, "R6 nothing stored", ov[1], 0);
    drain();

    @(negedge clk);
    done = 1'b1;
    for (int k = 0; k < N; k++)
      chk(sb[k].size() == 0, "R3 no word lost", sb[k].size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule